// File: doc/BRIEF.md
# Huffman Code-Length Search Engine

This block works out how long a canonical Huffman code is while its bits arrive, and forms the index into a symbol table that sits downstream. It holds two small banks of per-length limits, one for AC codes and one for DC codes. Each bank entry pairs a max-code value with a base offset. The banks are filled through a write port before decoding starts. Their contents have no reset.

A start pulse opens a new code. It carries the first two code bits and the bank choice for that code. A one-hot length selector is seeded at length 2. On every clock after that, the selector compares the gathered bits with the max-code of the selected length. If there is no fit, it shifts to the next length and appends one more code bit, up to length 9. When a fit is found, the block pulses done, presents the length in binary and presents the table index (base plus gathered bits), and the selector goes idle. If no length up to 9 fits, an error flag is raised and held.

Top module: `huff_len_search`

## Requirements
- R1: A synchronous active-high reset clears the length selector, done, code length, symbol address and error flag to zero.
- R2: With wr_en=1, the entry picked by the one-hot wr_sel is written with wr_maxc and wr_base in the bank chosen by wr_bank, where 1 is DC and 0 is AC. The other bank is unchanged. A scan reads from the bank given by start_bank at its start pulse, with the same encoding.
- R3: One cycle after a start pulse, len_sel equals 1, with bit 0 standing for length 2. The two lead bits become the gathered code value, with lead_bits[1] as the earlier bit.
- R4: While a scan is active and wr_en=0, len_sel moves up one bit position per clock until the scan ends. While wr_en=1, len_sel and the gathered value hold. len_sel never has more than one bit high.
- R5: A code fits at the selected length when the gathered value is less than or equal to that entry's max-code. A max-code of all ones (511) means the length has no codes and never fits.
- R6: A fit raises done for exactly one cycle, on the clock after the fitting cycle. On that cycle code_len holds the length (2 to 9) in binary and len_sel is zero.
- R7: sym_addr equals the fitting entry's base plus the gathered value, as a 10-bit sum. It stays unchanged until the next fit.
- R8: If length 9 does not fit, err rises one cycle later, len_sel clears and no done is produced. err holds until the next start pulse.
- R9: A start pulse during a scan abandons that scan, restarts at length 2 and clears err.
- R10: Each advance appends code_bit as the new least significant bit of the gathered value.
- R11: Reset does not alter the bank contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bank write enable; also pauses an active scan |
| wr_bank | input | 1 | Write bank: 1 DC, 0 AC |
| wr_sel | input | 8 | One-hot entry to write (bit i = length i+2) |
| wr_maxc | input | 9 | Max-code value to write |
| wr_base | input | 6 | Base offset to write |
| start | input | 1 | Start of a new code |
| start_bank | input | 1 | Bank for the new code: 1 DC, 0 AC |
| lead_bits | input | 2 | First two code bits, bit 1 earliest |
| code_bit | input | 1 | Next code bit, used on each advance |
| len_sel | output | 8 | One-hot length selector |
| done | output | 1 | One-cycle code-found strobe |
| code_len | output | 4 | Found code length, binary |
| sym_addr | output | 10 | Base plus gathered code value |
| err | output | 1 | Sticky no-fit flag |

## Verification
The seeded selector appears one clock after start. A code that fits at length L has done, code_len and sym_addr due L clocks after the start pulse, plus one clock for each cycle in which wr_en paused the scan. An overflow shows on err nine clocks after start, without pauses. The directed scenarios wait exactly those numbers of falling edges before they sample. Beside them, a behavioural model advances on every rising edge from the same inputs. It is compared with every output on the following falling edge, so each result is checked in the cycle in which it is due, and also in every cycle before and after.

// File: rtl/huff_len_pkg.sv
`timescale 1ns/1ps
package huff_len_pkg;
  typedef enum logic {BANK_AC = 1'b0, BANK_DC = 1'b1} bank_e;
endpackage

// File: rtl/len_table.sv
`timescale 1ns/1ps
// Two banks of per-length limits, written by one-hot entry, read by one-hot mux.
module len_table #(
  parameter int N_LEN  = 8,
  parameter int MAXC_W = 9,
  parameter int BASE_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [N_LEN-1:0]  wr_sel,
  input  logic [MAXC_W-1:0] wr_maxc,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              rd_bank,
  input  logic [N_LEN-1:0]  rd_sel,
  output logic [MAXC_W-1:0] rd_maxc,
  output logic [BASE_W-1:0] rd_base
);
  localparam int N_BANK = 2;

  logic [MAXC_W-1:0] bank_maxc [N_BANK];
  logic [BASE_W-1:0] bank_base [N_BANK];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [MAXC_W-1:0] maxc_q [N_LEN];
    logic [BASE_W-1:0] base_q [N_LEN];

    // No reset: contents survive rst (R11)
    always_ff @(posedge clk) begin
      for (int e = 0; e < N_LEN; e++) begin
        if (wr_en && (wr_bank == 1'(b)) && wr_sel[e]) begin
          maxc_q[e] <= wr_maxc;
          base_q[e] <= wr_base;
        end
      end
    end

    // One-hot AND-OR read; nothing selected reads as zero
    always_comb begin
      bank_maxc[b] = '0;
      bank_base[b] = '0;
      for (int e = 0; e < N_LEN; e++) begin
        if (rd_sel[e]) begin
          bank_maxc[b] = bank_maxc[b] | maxc_q[e];
          bank_base[b] = bank_base[b] | base_q[e];
        end
      end
    end
  end

  assign rd_maxc = bank_maxc[rd_bank];
  assign rd_base = bank_base[rd_bank];
endmodule

// File: rtl/len_selector.sv
`timescale 1ns/1ps
// One-hot length selector: seeded by start, shifts once per active cycle.
module len_selector #(
  parameter int N_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stall,
  input  logic             stop,
  output logic [N_LEN-1:0] sel,
  output logic             ran_off
);
  localparam logic [N_LEN-1:0] SEED = N_LEN'(1);

  // Last length is active and it neither fits nor is paused or restarted
  assign ran_off = sel[N_LEN-1] & ~start & ~stall & ~stop;

  always_ff @(posedge clk) begin
    if (rst)        sel <= '0;
    else if (start) sel <= SEED;
    else if (stall) sel <= sel;
    else if (stop)  sel <= '0;
    else            sel <= sel << 1;
  end
endmodule

// File: rtl/len_match.sv
`timescale 1ns/1ps
// Gathers code bits, tests them against the selected max-code, registers results.
module len_match #(
  parameter int N_LEN   = 8,
  parameter int MIN_LEN = 2,
  parameter int MAXC_W  = 9,
  parameter int BASE_W  = 6,
  parameter int LEN_W   = 4,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [MIN_LEN-1:0] lead_bits,
  input  logic               code_bit,
  input  logic               stall,
  input  logic [N_LEN-1:0]   sel,
  input  logic [MAXC_W-1:0]  rd_maxc,
  input  logic [BASE_W-1:0]  rd_base,
  input  logic               ran_off,
  output logic               hit,
  output logic               done,
  output logic [LEN_W-1:0]   code_len,
  output logic [ADDR_W-1:0]  sym_addr,
  output logic               err
);
  localparam logic [MAXC_W-1:0] NO_CODES = '1;

  logic [MAXC_W-1:0] acc_q;
  logic              active;

  function automatic logic code_fits(input logic [MAXC_W-1:0] acc,
                                     input logic [MAXC_W-1:0] maxc);
    return (maxc != NO_CODES) && (acc <= maxc);
  endfunction

  function automatic logic [ADDR_W-1:0] form_addr(input logic [BASE_W-1:0] base,
                                                  input logic [MAXC_W-1:0] acc);
    return ADDR_W'(base) + ADDR_W'(acc);
  endfunction

  function automatic logic [LEN_W-1:0] sel_to_len(input logic [N_LEN-1:0] s);
    logic [LEN_W-1:0] len;
    len = '0;
    for (int i = 0; i < N_LEN; i++) begin
      if (s[i]) len = LEN_W'(MIN_LEN + i);
    end
    return len;
  endfunction

  assign active = (|sel) & ~stall & ~start;
  assign hit    = active & code_fits(acc_q, rd_maxc);

  always_ff @(posedge clk) begin
    if (rst)                 acc_q <= '0;
    else if (start)          acc_q <= MAXC_W'(lead_bits);
    else if (active && !hit) acc_q <= {acc_q[MAXC_W-2:0], code_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      code_len <= '0;
      sym_addr <= '0;
    end else begin
      done <= hit;
      if (hit) begin
        code_len <= sel_to_len(sel);
        sym_addr <= form_addr(rd_base, acc_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) err <= 1'b0;
    else if (ran_off) err <= 1'b1;
  end
endmodule

// File: rtl/huff_len_search.sv
`timescale 1ns/1ps
module huff_len_search #(
  parameter int N_LEN   = 8,
  parameter int MIN_LEN = 2,
  parameter int MAXC_W  = 9,
  parameter int BASE_W  = 6,
  parameter int LEN_W   = $clog2(MIN_LEN + N_LEN),
  parameter int ADDR_W  = MAXC_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_bank,
  input  logic [N_LEN-1:0]   wr_sel,
  input  logic [MAXC_W-1:0]  wr_maxc,
  input  logic [BASE_W-1:0]  wr_base,
  input  logic               start,
  input  logic               start_bank,
  input  logic [MIN_LEN-1:0] lead_bits,
  input  logic               code_bit,
  output logic [N_LEN-1:0]   len_sel,
  output logic               done,
  output logic [LEN_W-1:0]   code_len,
  output logic [ADDR_W-1:0]  sym_addr,
  output logic               err
);
  import huff_len_pkg::*;

  bank_e             bank_q;
  logic [MAXC_W-1:0] rd_maxc;
  logic [BASE_W-1:0] rd_base;
  logic              hit_w;
  logic              ran_off_w;

  // Bank is fixed for the whole code at its start pulse
  always_ff @(posedge clk) begin
    if (start) bank_q <= bank_e'(start_bank);
  end

  len_table #(.N_LEN(N_LEN), .MAXC_W(MAXC_W), .BASE_W(BASE_W)) u_table (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (wr_bank),
    .wr_sel  (wr_sel),
    .wr_maxc (wr_maxc),
    .wr_base (wr_base),
    .rd_bank (bank_q == BANK_DC),
    .rd_sel  (len_sel),
    .rd_maxc (rd_maxc),
    .rd_base (rd_base)
  );

  len_selector #(.N_LEN(N_LEN)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stall   (wr_en),
    .stop    (hit_w),
    .sel     (len_sel),
    .ran_off (ran_off_w)
  );

  len_match #(
    .N_LEN(N_LEN), .MIN_LEN(MIN_LEN), .MAXC_W(MAXC_W),
    .BASE_W(BASE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_match (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .lead_bits (lead_bits),
    .code_bit  (code_bit),
    .stall     (wr_en),
    .sel       (len_sel),
    .rd_maxc   (rd_maxc),
    .rd_base   (rd_base),
    .ran_off   (ran_off_w),
    .hit       (hit_w),
    .done      (done),
    .code_len  (code_len),
    .sym_addr  (sym_addr),
    .err       (err)
  );
endmodule

// File: rtl/huff_len_search_chk.sv
`timescale 1ns/1ps
module huff_len_search_chk #(
  parameter int N_LEN   = 8,
  parameter int MIN_LEN = 2,
  parameter int LEN_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             wr_en,
  input logic [N_LEN-1:0] wr_sel,
  input logic [N_LEN-1:0] len_sel,
  input logic             done,
  input logic [LEN_W-1:0] code_len,
  input logic             err,
  input logic             hit_w,
  input logic             ran_off_w
);
  localparam int MAX_LEN = MIN_LEN + N_LEN - 1;

  p_wr_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $onehot0(wr_sel));

  p_seed_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (len_sel == N_LEN'(1)));

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(len_sel));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !start) |=> $stable(len_sel));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fit_done_r6: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> (done && (len_sel == '0)));

  p_len_range_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ((int'(code_len) >= MIN_LEN) && (int'(code_len) <= MAX_LEN)));

  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    ran_off_w |=> (err && (len_sel == '0) && !done));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> err);

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> !err);
endmodule

bind huff_len_search huff_len_search_chk #(
  .N_LEN(N_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .len_sel   (len_sel),
  .done      (done),
  .code_len  (code_len),
  .err       (err),
  .hit_w     (hit_w),
  .ran_off_w (ran_off_w)
);

// File: tb/test_huff_len_search.sv
`timescale 1ns/1ps
module test_huff_len_search;
  localparam int N = 8, MW = 9, BW = 6, LW = 4, AW = 10;

  logic          clk = 1'b0, rst = 1'b1;
  logic          wr_en = 1'b0, wr_bank = 1'b0;
  logic [N-1:0]  wr_sel = '0;
  logic [MW-1:0] wr_maxc = '0;
  logic [BW-1:0] wr_base = '0;
  logic          start = 1'b0, start_bank = 1'b0, code_bit = 1'b0;
  logic [1:0]    lead = '0;
  logic [N-1:0]  len_sel;
  logic          done, err;
  logic [LW-1:0] code_len;
  logic [AW-1:0] sym_addr;

  always #4 clk = ~clk;

  huff_len_search i_huff_len_search (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_sel(wr_sel),
    .wr_maxc(wr_maxc), .wr_base(wr_base), .start(start), .start_bank(start_bank),
    .lead_bits(lead), .code_bit(code_bit), .len_sel(len_sel), .done(done),
    .code_len(code_len), .sym_addr(sym_addr), .err(err)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_max [2][N];
  int m_base[2][N];
  int m_pos = -1, m_acc = 0, m_bank = 0, h = 0;
  int e_done = 0, e_len = 0, e_addr = 0, e_err = 0;
  bit m_on = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = -1; m_acc = 0; e_done = 0; e_len = 0; e_addr = 0; e_err = 0;
    end else begin
      h = 0;
      if (m_pos >= 0 && !wr_en && !start)
        h = (m_max[m_bank][m_pos] != 511) && (m_acc <= m_max[m_bank][m_pos]);
      e_done = h;
      if (h != 0) begin
        e_len  = m_pos + 2;
        e_addr = (m_base[m_bank][m_pos] + m_acc) % 1024;
      end
      if (start) begin
        m_pos = 0; m_acc = int'(lead); m_bank = int'(start_bank); e_err = 0;
      end else if (m_pos >= 0 && !wr_en) begin
        if (h != 0) m_pos = -1;
        else if (m_pos == N - 1) begin m_pos = -1; e_err = 1; end
        else begin m_pos++; m_acc = m_acc * 2 + int'(code_bit); end
      end
    end
    if (wr_en)
      for (int e = 0; e < N; e++)
        if (wr_sel[e]) begin
          m_max[wr_bank][e]  = int'(wr_maxc);
          m_base[wr_bank][e] = int'(wr_base);
        end
  end

  always @(negedge clk) begin
    if (m_on) begin
      chk("R4 model len_sel", int'(len_sel), (m_pos >= 0) ? (1 << m_pos) : 0);
      chk("R6 model done", int'(done), e_done);
      chk("R6 model code_len", int'(code_len), e_len);
      chk("R7 model sym_addr", int'(sym_addr), e_addr);
      chk("R8 model err", int'(err), e_err);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  task automatic begin_code(input logic bank, input logic [1:0] lb);
    @(negedge clk);
    start = 1'b1; start_bank = bank; lead = lb;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 len_sel", int'(len_sel), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 sym_addr", int'(sym_addr), 0);
    rst = 1'b0; m_on = 1'b1;

    // Load: AC max (3<<i)-1 except length 2 empty (511); DC max 1<<(i+1)
    for (int i = 0; i < N; i++)
      for (int b = 0; b < 2; b++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b[0]; wr_sel = N'(1) << i;
        wr_maxc = (b == 0) ? ((i == 0) ? 9'd511 : MW'((3 << i) - 1)) : MW'(1 << (i + 1));
        wr_base = (b == 0) ? BW'(i * 5 + 1) : BW'(63 - 3 * i);
      end
    @(negedge clk); wr_en = 1'b0; wr_sel = '0;

    // R2/R5: DC bank, bits 00 fit at length 2 (max 2), base 63
    begin_code(1'b1, 2'b00);
    @(negedge clk); start = 1'b0; code_bit = 1'b0;
    @(negedge clk);
    chk("R2 dc done", int'(done), 1);
    chk("R2 dc code_len", int'(code_len), 2);
    chk("R2 dc sym_addr", int'(sym_addr), 63);

    // R3/R5/R10: AC bank, length 2 empty, 000 fits at length 3 (base 6)
    begin_code(1'b0, 2'b00);
    @(negedge clk); start = 1'b0; code_bit = 1'b0;
    chk("R3 seed", int'(len_sel), 1);
    @(negedge clk);
    chk("R5 empty length skipped", int'(len_sel), 2);
    @(negedge clk);
    chk("R10 ac done", int'(done), 1);
    chk("R10 ac code_len", int'(code_len), 3);
    chk("R7 ac sym_addr", int'(sym_addr), 6);

    // R5 boundary: 101 equals AC length-3 max 5 -> fits, addr 6+5
    begin_code(1'b0, 2'b10);
    @(negedge clk); start = 1'b0; code_bit = 1'b1;
    @(negedge clk); code_bit = 1'b0;
    @(negedge clk);
    chk("R5 equal fits", int'(done), 1);
    chk("R5 equal sym_addr", int'(sym_addr), 11);

    // R8: all-ones code exceeds every AC max
    begin_code(1'b0, 2'b11);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); start = 1'b0; code_bit = 1'b1;
    end
    @(negedge clk);
    chk("R8 err set", int'(err), 1);
    chk("R8 sel cleared", int'(len_sel), 0);
    chk("R8 no done", int'(done), 0);
    @(negedge clk);
    chk("R8 err held", int'(err), 1);

    // R9: restart mid-scan on DC
    begin_code(1'b0, 2'b11);
    @(negedge clk); start = 1'b0; code_bit = 1'b1;
    @(negedge clk);
    begin_code(1'b1, 2'b00);
    @(negedge clk); start = 1'b0;
    chk("R9 reseeded", int'(len_sel), 1);
    chk("R9 err cleared", int'(err), 0);
    @(negedge clk);
    chk("R9 done", int'(done), 1);
    chk("R9 code_len", int'(code_len), 2);

    // R4: wr_en pauses the scan
    begin_code(1'b0, 2'b11);
    @(negedge clk); start = 1'b0; wr_en = 1'b1; wr_sel = '0;
    @(negedge clk);
    chk("R4 held", int'(len_sel), 1);
    wr_en = 1'b0; code_bit = 1'b1;
    @(negedge clk);
    chk("R4 advanced", int'(len_sel), 2);

    // R11: reset leaves banks intact
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset sel", int'(len_sel), 0);
    begin_code(1'b1, 2'b00);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk("R11 done", int'(done), 1);
    chk("R11 sym_addr", int'(sym_addr), 63);

    // Mixed traffic compared against the model every cycle
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      code_bit   = lfsr[0];
      start      = (lfsr[7:4] == 4'd0);
      start_bank = lfsr[8];
      lead       = lfsr[10:9];
      wr_en      = (lfsr[15:12] == 4'hF);
      wr_bank    = lfsr[11];
      wr_sel     = wr_en ? (N'(1) << lfsr[3:1]) : '0;
      wr_maxc    = {lfsr[6:0], lfsr[14:13]};
      wr_base    = lfsr[13:8];
    end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0; wr_sel = '0;
    repeat (12) @(negedge clk);
    summary();
    $finish;
  end
endmodule